// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Writes

This block is a synthesizable synchronous static RAM with its own address, burst and write logic. Every input (address, write data, strobes, chip enables and write controls) is captured on the rising clock edge. A memory access is started by one of two active-low address strobes. The processor strobe always starts a read. The controller strobe starts a read or a write, depending on the write controls it sees in the same cycle. After a burst has started, an active-low advance input steps a 2-bit counter. The counter replaces the two low bits of the loaded address, in either linear or interleaved order.

A write covers any mix of the byte lanes. A lane is written when the shared byte-write enable is low together with that lane's own select. A global write input overrides both and writes the whole word. Three chip enables must all be active when a strobe arrives, or the strobe is ignored or deselects the device. Read data comes out of a registered output stage with a valid flag. The output is held at zero whenever no read is being returned. The memory depth is a parameter and is kept small.

Top module: `sync_burst_sram`

## Requirements
- R1: An access is decided from the inputs present at rising edge k. Read data for it is shown on `rdata` with `rdata_vld` high after edge k+1, and stays until edge k+2. A write captured at edge k is visible to a read captured at edge k+1.
- R2: A low `proc_stb_n` while the device is selected loads `addr`, clears the burst count and performs a read. The write controls are ignored in that cycle.
- R3: A low `ctrl_stb_n` while `proc_stb_n` is high and the device is selected loads `addr` and clears the burst count. It writes in that same cycle if `all_wr_n` is low, or if `bw_en_n` is low with at least one `bw_sel_n` bit low. Otherwise it reads.
- R4: With `all_wr_n` high and `bw_en_n` low, only the lanes whose `bw_sel_n[i]` is low are written, where lane i is data bits [8i+7:8i]. The other lanes keep their old contents. With `bw_en_n` high, `bw_sel_n` has no effect and the cycle is a read.
- R5: A low `all_wr_n` on a write cycle writes all four lanes, whatever `bw_en_n` and `bw_sel_n` hold.
- R6: With `order_sel` low (linear), the n-th advance after a burst start gives low address bits (start + n) mod 4. The upper address bits stay as loaded.
- R7: With `order_sel` high (interleaved), the n-th advance gives low address bits start XOR (n mod 4).
- R8: A cycle with no strobe, an active burst and `adv_n` high accesses the same address as the previous cycle.
- R9: A new strobe during an active burst reloads the address and restarts the count from zero.
- R10: The device counts as selected only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. A low `ctrl_stb_n` while not selected ends the burst at once. No access is made from that cycle on, so `rdata_vld` is low and `rdata` is zero after the next edge.
- R11: A low `proc_stb_n` while not selected is ignored. The cycle behaves as if no strobe were present: an active burst continues, and an idle device stays idle.
- R12: While `rst` is high, and after it is released until a strobe starts a burst, `rdata_vld` is low and `rdata` is zero.
- R13: A cycle with no strobe during an active burst writes the current burst address when the write controls ask for a write (as in R3 to R5). Otherwise it reads that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| cs_c_n | input | 1 | Chip enable, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low, read only |
| ctrl_stb_n | input | 1 | Controller address strobe, active low, read or write |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| all_wr_n | input | 1 | Global whole-word write, active low |
| bw_en_n | input | 1 | Byte-write enable, active low |
| bw_sel_n | input | LANES | Per-lane byte-write select, active low |
| addr | input | ADDR_W | Word address loaded by a strobe |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data, zero when not valid |
| rdata_vld | output | 1 | Read data valid (output enable) |

## Verification
Some rules are checked by assertions on every cycle. The output is zero whenever the valid flag is low, and a write cycle never raises the valid flag. A processor-strobe start is captured as a read. The burst count holds without advance, steps by one with advance, and clears on reload. A controller-strobe deselect drops the output one cycle later. Other behaviour can only be shown by the bench scenarios: which addresses a linear or interleaved burst actually visits, which lanes a byte write touches while the others keep their contents, and that an ignored processor strobe leaves a running burst intact. The bench scenarios compare every output cycle against a reference memory and burst model kept in the bench.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    // Strobe, advance and selection flags after polarity correction
    typedef struct packed {
        logic proc;   // processor strobe asserted
        logic ctrl;   // controller strobe asserted
        logic adv;    // advance asserted
        logic ilv;    // interleaved order chosen
        logic sel;    // all three chip enables active
    } sbs_ctl_t;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_CONT  = 2'd2,
        EV_DESEL = 2'd3
    } sbs_event_e;

    // Low two address bits for burst step cnt from start value st
    function automatic logic [1:0] burst_low(input logic [1:0] st,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (st ^ cnt) : (st + cnt);
    endfunction

endpackage

// File: rtl/sbs_wr_decode.sv
module sbs_wr_decode #(
    parameter int LANES = 4
) (
    input  logic             all_wr_n,
    input  logic             bw_en_n,
    input  logic [LANES-1:0] bw_sel_n,
    output logic [LANES-1:0] lane_mask,
    output logic             wr_req
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = !all_wr_n || (!bw_en_n && !bw_sel_n[g]);
    end

    assign wr_req = |lane_mask;

endmodule

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  sbs_ctl_t          ctl,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_req,
    output logic              acc_vld,
    output logic              acc_wr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic              active_q;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;

    logic              start_p;
    logic              start_c;
    sbs_event_e        ev;
    logic [ADDR_W-1:0] base_nxt;
    logic [1:0]        cnt_nxt;
    logic              active_nxt;

    assign start_p = ctl.proc && ctl.sel;
    assign start_c = ctl.ctrl && ctl.sel && !ctl.proc;

    always_comb begin
        if (start_p || start_c)           ev = EV_START;
        else if (ctl.ctrl && !ctl.sel)    ev = EV_DESEL;
        else if (active_q)                ev = EV_CONT;
        else                              ev = EV_NONE;
    end

    always_comb begin
        base_nxt   = base_q;
        cnt_nxt    = cnt_q;
        active_nxt = active_q;
        unique case (ev)
            EV_START: begin
                base_nxt   = addr_in;
                cnt_nxt    = 2'd0;
                active_nxt = 1'b1;
            end
            EV_CONT:  if (ctl.adv) cnt_nxt = cnt_q + 2'd1;
            EV_DESEL: active_nxt = 1'b0;
            default:  ;
        endcase
    end

    assign acc_vld  = (ev == EV_START) || (ev == EV_CONT);
    assign acc_wr   = acc_vld && !start_p && wr_req;
    assign acc_addr = {base_nxt[ADDR_W-1:2], burst_low(base_nxt[1:0], cnt_nxt, ctl.ilv)};

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            cnt_q    <= 2'd0;
        end else begin
            active_q <= active_nxt;
            base_q   <= base_nxt;
            cnt_q    <= cnt_nxt;
        end
    end

    // R8
    ctr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_CONT && !ctl.adv) |=> (cnt_q == $past(cnt_q)));

    // R6
    ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_CONT && ctl.adv) |=> (cnt_q == $past(cnt_q) + 2'd1));

    // R9
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (start_p || start_c) |=> (cnt_q == 2'd0 && base_q == $past(addr_in) && active_q));

endmodule

// File: rtl/sbs_mem_array.sv
module sbs_mem_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     acc_vld,
    input  logic                     acc_wr,
    input  logic [ADDR_W-1:0]        acc_addr,
    input  logic [LANES-1:0]         lane_mask,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_vld
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] rd_word;
    logic              do_rd;

    assign do_rd = acc_vld && !acc_wr;

    for (genvar g = 0; g < LANES; g++) begin : g_bank
        logic [LANE_W-1:0] bank [DEPTH];

        always_ff @(posedge clk) begin
            if (acc_vld && acc_wr && lane_mask[g])
                bank[acc_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rd_word[g*LANE_W +: LANE_W] = bank[acc_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata     <= do_rd ? rd_word : '0;
            rdata_vld <= do_rd;
        end
    end

    // R12
    out_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rdata_vld |-> (rdata == '0));

    // R3
    wr_no_out_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && acc_wr) |=> !rdata_vld);

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_a_n,
    input  logic                     cs_b,
    input  logic                     cs_c_n,
    input  logic                     proc_stb_n,
    input  logic                     ctrl_stb_n,
    input  logic                     adv_n,
    input  logic                     order_sel,
    input  logic                     all_wr_n,
    input  logic                     bw_en_n,
    input  logic [LANES-1:0]         bw_sel_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     rdata_vld
);

    localparam int DATA_W = LANES * LANE_W;

    sbs_ctl_t          ctl;
    logic [LANES-1:0]  lane_mask;
    logic              wr_req;
    logic              acc_vld;
    logic              acc_wr;
    logic [ADDR_W-1:0] acc_addr;

    // Access stage registers
    logic              s1_vld;
    logic              s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;
    logic [DATA_W-1:0] s1_wdata;

    assign ctl.proc = !proc_stb_n;
    assign ctl.ctrl = !ctrl_stb_n;
    assign ctl.adv  = !adv_n;
    assign ctl.ilv  = order_sel;
    assign ctl.sel  = !cs_a_n && cs_b && !cs_c_n;

    sbs_wr_decode #(.LANES(LANES)) i_dec (
        .all_wr_n  (all_wr_n),
        .bw_en_n   (bw_en_n),
        .bw_sel_n  (bw_sel_n),
        .lane_mask (lane_mask),
        .wr_req    (wr_req)
    );

    sbs_burst_ctrl #(.ADDR_W(ADDR_W)) i_burst (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .addr_in  (addr),
        .wr_req   (wr_req),
        .acc_vld  (acc_vld),
        .acc_wr   (acc_wr),
        .acc_addr (acc_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld   <= 1'b0;
            s1_wr    <= 1'b0;
            s1_addr  <= '0;
            s1_mask  <= '0;
            s1_wdata <= '0;
        end else begin
            s1_vld   <= acc_vld;
            s1_wr    <= acc_wr;
            s1_addr  <= acc_addr;
            s1_mask  <= lane_mask;
            s1_wdata <= wdata;
        end
    end

    sbs_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_mem (
        .clk       (clk),
        .rst       (rst),
        .acc_vld   (s1_vld),
        .acc_wr    (s1_wr),
        .acc_addr  (s1_addr),
        .lane_mask (s1_mask),
        .wdata     (s1_wdata),
        .rdata     (rdata),
        .rdata_vld (rdata_vld)
    );

    // R2
    proc_read_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.proc && ctl.sel) |=> (s1_vld && !s1_wr));

    // R10
    desel_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.ctrl && !ctl.sel) |=> ##1 (!rdata_vld && rdata == '0));

    // R11
    idle_ign_chk: assert property (@(posedge clk) disable iff (rst)
        (!s1_vld && !ctl.ctrl && !(ctl.proc && ctl.sel)) |=> !s1_vld);

endmodule

// File: tb/test_sync_burst_sram.sv
`timescale 1ns/1ps
module test_sync_burst_sram;

    localparam int AW = 6;
    localparam int NB = 4;
    localparam int DW = NB * 8;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst;
    logic          cs_a_n, cs_b, cs_c_n;
    logic          proc_stb_n, ctrl_stb_n, adv_n, order_sel;
    logic          all_wr_n, bw_en_n;
    logic [NB-1:0] bw_sel_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          rdata_vld;

    sync_burst_sram #(.ADDR_W(AW), .LANES(NB), .LANE_W(8)) i_sync_burst_sram (
        .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .order_sel(order_sel), .all_wr_n(all_wr_n), .bw_en_n(bw_en_n),
        .bw_sel_n(bw_sel_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld)
    );

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Reference model
    logic [DW-1:0] refm [DEPTH];
    bit            m_act;
    logic [AW-1:0] m_base;
    logic [1:0]    m_cnt;
    bit            pv, pw;
    logic [AW-1:0] pa;
    logic [NB-1:0] pm;
    logic [DW-1:0] pwd;

    function automatic logic [1:0] exp_low(input logic [1:0] s, input logic [1:0] c,
                                           input logic ilv);
        if (ilv) return s ^ c;
        return s + c;
    endfunction

    function automatic logic [DW-1:0] pattern(input int a);
        return {8'(a * 7 + 3), 8'(a ^ 8'h5A), 8'(a + 8'h80), 8'(a)};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic idle_in();
        cs_a_n = 0; cs_b = 1; cs_c_n = 0;
        proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1;
        all_wr_n = 1; bw_en_n = 1; bw_sel_n = '1;
        addr = '0; wdata = '0;
    endtask

    // Called at a falling edge with inputs set; returns at the next falling edge
    task automatic tick(input string tag);
        logic [DW-1:0] ev;
        logic          evl;
        logic          sel, sp, sc, ds, cont;
        logic [NB-1:0] msk;
        @(posedge clk);
        if (rst) begin
            m_act = 0; pv = 0; pw = 0;
            evl = 0; ev = '0;
        end else begin
            if (pv && pw)
                for (int b = 0; b < NB; b++)
                    if (pm[b]) refm[pa][b*8 +: 8] = pwd[b*8 +: 8];
            evl = pv && !pw;
            ev  = evl ? refm[pa] : '0;
            sel  = !cs_a_n && cs_b && !cs_c_n;
            sp   = !proc_stb_n && sel;
            sc   = !ctrl_stb_n && sel && proc_stb_n;
            ds   = !ctrl_stb_n && !sel;
            msk  = !all_wr_n ? '1 : (!bw_en_n ? ~bw_sel_n : '0);
            cont = !sp && !sc && !ds && m_act;
            if (sp || sc) begin m_base = addr; m_cnt = 0; m_act = 1; end
            else if (ds) m_act = 0;
            else if (cont && !adv_n) m_cnt = m_cnt + 2'd1;
            pv  = sp || sc || cont;
            pw  = (sc || cont) && (msk != '0);
            pa  = {m_base[AW-1:2], exp_low(m_base[1:0], m_cnt, order_sel)};
            pm  = msk;
            pwd = wdata;
        end
        #1;
        chk(tag, "rdata_vld", 64'(rdata_vld), 64'(evl));
        chk(tag, "rdata", 64'(rdata), 64'(ev));
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        m_act = 0; pv = 0; pw = 0; m_base = '0; m_cnt = '0;
        pa = '0; pm = '0; pwd = '0;
        idle_in();
        order_sel = 0;
        rst = 1;
        @(negedge clk);
        // R12: reset state, even with a strobe present
        proc_stb_n = 0;
        repeat (3) tick("R12");
        proc_stb_n = 1;
        rst = 0;
        repeat (2) tick("R12");

        // R5: fill every word by global write with byte enables off
        for (int a = 0; a < DEPTH; a++) begin
            idle_in(); ctrl_stb_n = 0; all_wr_n = 0; bw_en_n = 1; bw_sel_n = '1;
            addr = AW'(a); wdata = pattern(a);
            tick("R5");
        end
        // R10: deselect by controller strobe with cs_b low
        idle_in(); ctrl_stb_n = 0; cs_b = 0; tick("R10");
        idle_in(); tick("R10"); tick("R10");

        // R11: processor strobe while not selected is ignored when idle
        idle_in(); proc_stb_n = 0; cs_c_n = 1; addr = 6'd3; tick("R11");
        idle_in(); tick("R11"); tick("R11");

        // R2, R1, R6: processor read with write inputs present, linear burst
        idle_in(); proc_stb_n = 0; all_wr_n = 0; addr = 6'd5; wdata = '1; tick("R2");
        for (int i = 0; i < 5; i++) begin idle_in(); adv_n = 0; tick("R6"); end
        idle_in(); tick("R1");

        // R7: interleaved burst
        order_sel = 1;
        idle_in(); proc_stb_n = 0; addr = 6'd21; tick("R7");
        for (int i = 0; i < 5; i++) begin idle_in(); adv_n = 0; tick("R7"); end
        // R8: hold without advance
        for (int i = 0; i < 3; i++) begin idle_in(); tick("R8"); end
        // R9: reload mid burst
        idle_in(); proc_stb_n = 0; addr = 6'd42; tick("R9");
        idle_in(); adv_n = 0; tick("R9"); tick("R9");
        order_sel = 0;

        // R11: ignored processor strobe during an active burst
        idle_in(); proc_stb_n = 0; cs_a_n = 1; adv_n = 0; addr = 6'd0; tick("R11");
        idle_in(); adv_n = 0; tick("R11"); tick("R11");

        // R4: byte write of lanes 0 and 2, then read back
        idle_in(); ctrl_stb_n = 0; bw_en_n = 0; bw_sel_n = 4'b1010;
        addr = 6'd9; wdata = 32'hA1B2_C3D4; tick("R4");
        idle_in(); proc_stb_n = 0; addr = 6'd9; tick("R4");
        // R4: byte selects without enable give a read
        idle_in(); ctrl_stb_n = 0; bw_en_n = 1; bw_sel_n = 4'b0000;
        addr = 6'd9; wdata = 32'hFFFF_FFFF; tick("R4");
        idle_in(); tick("R4"); tick("R4");

        // R3 and R13: controller read, then continuation write, then read back
        idle_in(); ctrl_stb_n = 0; addr = 6'd12; tick("R3");
        idle_in(); adv_n = 0; all_wr_n = 0; wdata = 32'h1357_9BDF; tick("R13");
        idle_in(); adv_n = 0; bw_en_n = 0; bw_sel_n = 4'b0111; wdata = 32'hEE00_0000; tick("R13");
        idle_in(); proc_stb_n = 0; addr = 6'd13; tick("R13");
        idle_in(); adv_n = 0; tick("R13"); tick("R13");
        // R1: write then immediate read of same word
        idle_in(); ctrl_stb_n = 0; all_wr_n = 0; addr = 6'd30; wdata = 32'hCAFE_F00D; tick("R1");
        idle_in(); proc_stb_n = 0; addr = 6'd30; tick("R1");
        idle_in(); tick("R1");

        // R10: deselect in the middle of a burst, each enable in turn
        for (int k = 0; k < 3; k++) begin
            idle_in(); proc_stb_n = 0; addr = 6'(k * 11); tick("R10");
            idle_in(); ctrl_stb_n = 0;
            if (k == 0) cs_a_n = 1; else if (k == 1) cs_b = 0; else cs_c_n = 1;
            tick("R10");
            idle_in(); adv_n = 0; tick("R10"); tick("R10");
        end

        // Random mix, R1 through R13 against the model
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom;
            idle_in();
            if ((i % 500) == 0) order_sel = $urandom_range(0, 1);
            cs_a_n     = ($urandom_range(0, 9) == 0);
            cs_b       = ($urandom_range(0, 9) != 0);
            cs_c_n     = ($urandom_range(0, 9) == 0);
            proc_stb_n = ($urandom_range(0, 5) != 0);
            ctrl_stb_n = ($urandom_range(0, 5) != 0);
            adv_n      = r[0];
            all_wr_n   = ($urandom_range(0, 7) != 0);
            bw_en_n    = r[1] | r[2];
            bw_sel_n   = r[7:4];
            addr       = AW'($urandom);
            wdata      = $urandom;
            tick("R1");
        end
        idle_in(); ctrl_stb_n = 0; cs_b = 0; tick("R10");
        idle_in(); tick("R10");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule